// File: doc/BRIEF.md
# Soft-Resettable Register Field

This block is a single software-writable register field that has two independent ways back to a known state. The first is the chip-wide hard reset, which is asynchronous and active-low and always restores a fixed build-time constant. The second is a soft reset input. It returns the field to a value chosen when the block is built: the live contents of a neighbouring register field, the live level of a hardware input, or a build-time constant. Software updates the field through a plain write strobe and a data word. Bus decoding sits upstream.

Parameters decide whether the soft reset acts at the clock edge (synchronous) or as soon as it is asserted (asynchronous), and whether it is active-high or active-low. In asynchronous mode the field takes the source value present at the moment of assertion. It reloads the source at every clock edge for as long as the soft reset stays asserted. When the soft reset is released, the field keeps the last value it loaded.

Top module: `srst_field`

## Requirements
- R1: While `hard_rst_n` is low, `field_q` equals `HARD_VAL` (default 8'h5A). This holds immediately and regardless of the soft reset or a write.
- R2: With the soft reset inactive, a rising clock edge with `wr_en` high loads `wr_data` into `field_q`.
- R3: With the soft reset inactive and `wr_en` low, `field_q` keeps its value across clock edges, whatever `wr_data` carries.
- R4: With `SRC_SEL` = 0, a soft reset loads the value present on `peer_field`.
- R5: With `SRC_SEL` = 1, a soft reset loads the value present on `hw_src`.
- R6: With `SRC_SEL` = 2, a soft reset loads the constant `SOFT_VAL` (default 8'hC3). Both source inputs are ignored.
- R7: When the soft reset and `wr_en` are both active at the same edge, the soft-reset value wins and the write is dropped.
- R8: With `SRST_ASYNC` = 0, asserting the soft reset leaves `field_q` unchanged until the next rising clock edge.
- R9: With `SRST_ASYNC` = 1, `field_q` takes the source value as soon as the soft reset is asserted, before any clock edge. At each clock edge while the soft reset is held, the field reloads the source. After release, the field holds the last value loaded.
- R10: With `SRST_ACT_HIGH` = 1 the soft reset is active when `soft_rst` is 1. With `SRST_ACT_HIGH` = 0 it is active when `soft_rst` is 0. The opposite level has no effect on the field.
- R11: Once the soft reset is released, software writes take effect again at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Soft reset, polarity set by `SRST_ACT_HIGH` |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | WIDTH | Software write data |
| peer_field | input | WIDTH | Current value of the neighbouring register field |
| hw_src | input | WIDTH | Hardware input used as a soft-reset source |
| field_q | output | WIDTH | Field contents |

## Verification
Writes, holds and synchronous soft-reset loads all appear one rising edge after they are presented. The bench therefore drives inputs on a falling edge and compares `field_q` on the following falling edge. In asynchronous mode the soft-reset load appears within the same cycle. The bench checks it 2 ns after assertion, and in the same window it confirms that a synchronous instance has not moved yet. The hard reset is also checked 2 ns after it falls, which shows that it does not wait for a clock.

// File: rtl/srst_field_pkg.sv
package srst_field_pkg;

  typedef enum int {
    SRC_PEER  = 0,
    SRC_HWIN  = 1,
    SRC_PARAM = 2
  } srst_src_e;

  function automatic logic srst_active(input logic level, input bit act_high);
    return act_high ? level : ~level;
  endfunction

  function automatic bit src_is_valid(input int sel);
    return (sel == SRC_PEER) || (sel == SRC_HWIN) || (sel == SRC_PARAM);
  endfunction

endpackage

// File: rtl/srst_level_norm.sv
module srst_level_norm #(
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic soft_rst_i,
  output logic srst_on_o
);
  import srst_field_pkg::*;

  generate
    if (ACT_HIGH) begin : g_high
      assign srst_on_o = srst_active(soft_rst_i, 1'b1);
    end else begin : g_low
      assign srst_on_o = srst_active(soft_rst_i, 1'b0);
    end
  endgenerate
endmodule

// File: rtl/srst_reload_sel.sv
module srst_reload_sel #(
  parameter int              WIDTH     = 8,
  parameter int              SRC_SEL   = 0,
  parameter logic [WIDTH-1:0] PARAM_VAL = 8'hC3
) (
  input  logic [WIDTH-1:0] peer_i,
  input  logic [WIDTH-1:0] hw_i,
  output logic [WIDTH-1:0] reload_o
);
  import srst_field_pkg::*;

  initial begin
    if (!src_is_valid(SRC_SEL)) $error("srst_reload_sel: bad SRC_SEL %0d", SRC_SEL);
  end

  always_comb begin
    case (SRC_SEL)
      SRC_PEER: reload_o = peer_i;
      SRC_HWIN: reload_o = hw_i;
      default:  reload_o = PARAM_VAL;
    endcase
  end
endmodule

// File: rtl/srst_field_store.sv
module srst_field_store #(
  parameter int              WIDTH    = 8,
  parameter bit              ASYNC    = 1'b0,
  parameter logic [WIDTH-1:0] HARD_VAL = 8'h5A
) (
  input  logic             clk,
  input  logic             hard_rst_n,
  input  logic             srst_on,
  input  logic [WIDTH-1:0] reload,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] q
);
  generate
    if (ASYNC) begin : g_async
      always_ff @(posedge clk or negedge hard_rst_n or posedge srst_on) begin
        if (!hard_rst_n)  q <= HARD_VAL;
        else if (srst_on) q <= reload;
        else if (wr_en)   q <= wr_data;
      end
    end else begin : g_sync
      always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n)  q <= HARD_VAL;
        else if (srst_on) q <= reload;
        else if (wr_en)   q <= wr_data;
      end
    end
  endgenerate
endmodule

// File: rtl/srst_field.sv
module srst_field #(
  parameter int               WIDTH         = 8,
  parameter logic [WIDTH-1:0] HARD_VAL      = 8'h5A,
  parameter logic [WIDTH-1:0] SOFT_VAL      = 8'hC3,
  parameter int               SRC_SEL       = 0,
  parameter bit               SRST_ASYNC    = 1'b0,
  parameter bit               SRST_ACT_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             hard_rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] peer_field,
  input  logic [WIDTH-1:0] hw_src,
  output logic [WIDTH-1:0] field_q
);
  logic             srst_on;
  logic [WIDTH-1:0] reload_val;

  srst_level_norm #(.ACT_HIGH(SRST_ACT_HIGH)) u_norm (
    .soft_rst_i(soft_rst),
    .srst_on_o (srst_on)
  );

  srst_reload_sel #(.WIDTH(WIDTH), .SRC_SEL(SRC_SEL), .PARAM_VAL(SOFT_VAL)) u_sel (
    .peer_i  (peer_field),
    .hw_i    (hw_src),
    .reload_o(reload_val)
  );

  srst_field_store #(.WIDTH(WIDTH), .ASYNC(SRST_ASYNC), .HARD_VAL(HARD_VAL)) u_store (
    .clk       (clk),
    .hard_rst_n(hard_rst_n),
    .srst_on   (srst_on),
    .reload    (reload_val),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .q         (field_q)
  );
endmodule

// File: rtl/srst_field_chk.sv
module srst_field_chk #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] HARD_VAL = 8'h5A,
  parameter logic [WIDTH-1:0] SOFT_VAL = 8'hC3,
  parameter int               SRC_SEL  = 0
) (
  input logic             clk,
  input logic             hard_rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] peer_field,
  input logic [WIDTH-1:0] hw_src,
  input logic [WIDTH-1:0] field_q,
  input logic             srst_on,
  input logic [WIDTH-1:0] reload_val
);
  logic [WIDTH-1:0] want_src;
  always_comb begin
    if (SRC_SEL == 0)      want_src = peer_field;
    else if (SRC_SEL == 1) want_src = hw_src;
    else                   want_src = SOFT_VAL;
  end

  assert_hard_val_R1: assert property (@(posedge clk)
    !hard_rst_n |-> field_q == HARD_VAL);

  assert_write_R2: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (wr_en && !srst_on) ##1 !srst_on |-> field_q == $past(wr_data));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!wr_en && !srst_on) ##1 !srst_on |-> $stable(field_q));

  // R4 R5 R6: source chosen by SRC_SEL reaches the field
  assert_src_load_R4: assert property (@(posedge clk) disable iff (!hard_rst_n)
    srst_on |=> field_q == $past(want_src));

  assert_soft_wins_R7: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (srst_on && wr_en) |=> field_q == $past(reload_val));
endmodule

bind srst_field srst_field_chk #(
  .WIDTH(WIDTH), .HARD_VAL(HARD_VAL), .SOFT_VAL(SOFT_VAL), .SRC_SEL(SRC_SEL)
) u_chk (
  .clk(clk), .hard_rst_n(hard_rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .peer_field(peer_field), .hw_src(hw_src), .field_q(field_q),
  .srst_on(srst_on), .reload_val(reload_val)
);

// File: tb/srst_field_tb.sv
`timescale 1ns/1ps
module srst_field_tb;
  logic       clk = 1'b0;
  logic       hard_rst_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] peer_v = 8'h00;
  logic [7:0] hw_v = 8'h00;
  logic       sr_a = 1'b0;
  logic       sr_b_n = 1'b1;
  logic       sr_c_n = 1'b1;
  logic [7:0] qa, qb, qc;
  logic [7:0] exp_a, exp_b, exp_c;
  logic       b_was_on = 1'b0;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  localparam logic [7:0] HARD = 8'h5A;
  localparam logic [7:0] SOFT = 8'hC3;

  always #10 clk = ~clk;

  // peer source, synchronous, active-high
  srst_field #(.SRC_SEL(0), .SRST_ASYNC(1'b0), .SRST_ACT_HIGH(1'b1)) u_dut (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(sr_a), .wr_en(wr_en),
    .wr_data(wr_data), .peer_field(peer_v), .hw_src(hw_v), .field_q(qa));
  // hardware input source, asynchronous, active-low
  srst_field #(.SRC_SEL(1), .SRST_ASYNC(1'b1), .SRST_ACT_HIGH(1'b0)) u_dut_hw (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(sr_b_n), .wr_en(wr_en),
    .wr_data(wr_data), .peer_field(peer_v), .hw_src(hw_v), .field_q(qb));
  // constant source, synchronous, active-low
  srst_field #(.SRC_SEL(2), .SRST_ASYNC(1'b0), .SRST_ACT_HIGH(1'b0)) u_dut_par (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(sr_c_n), .wr_en(wr_en),
    .wr_data(wr_data), .peer_field(peer_v), .hw_src(hw_v), .field_q(qc));

  task automatic check(input string tag, input string who,
                       input logic [7:0] got, input logic [7:0] want);
    n_checks++;
    if (got !== want) begin
      n_errors++;
      $display("FAIL %s %s: got %02h expected %02h at %0t", tag, who, got, want, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // Called right after a falling edge; returns at the next falling edge.
  task automatic drive(input bit wr, input logic [7:0] d, input bit sa, input bit sb,
                       input bit sc, input logic [7:0] p, input logic [7:0] h);
    wr_en = wr; wr_data = d; peer_v = p; hw_v = h;
    sr_a = sa; sr_b_n = !sb; sr_c_n = !sc;
    if (sb && !b_was_on) begin
      #2;
      check("R9", "async load before edge", qb, h);
      check("R8", "sync peer unchanged before edge", qa, exp_a);
      check("R8", "sync param unchanged before edge", qc, exp_c);
      exp_b = h;
    end
    b_was_on = sb;
    @(posedge clk);
    exp_a = sa ? p : (wr ? d : exp_a);
    exp_b = sb ? h : (wr ? d : exp_b);
    exp_c = sc ? SOFT : (wr ? d : exp_c);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    #1 hard_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "peer", qa, HARD); check("R1", "hw", qb, HARD); check("R1", "param", qc, HARD);
    wr_en = 1'b1; wr_data = 8'h11; sr_a = 1'b1; sr_b_n = 1'b0; sr_c_n = 1'b0;
    peer_v = 8'h22; hw_v = 8'h33;
    repeat (2) @(negedge clk);
    check("R1", "peer over soft", qa, HARD); check("R1", "hw over soft", qb, HARD);
    check("R1", "param over soft", qc, HARD);
    wr_en = 1'b0; sr_a = 1'b0; sr_b_n = 1'b1; sr_c_n = 1'b1;
    @(negedge clk);
    hard_rst_n = 1'b1;
    exp_a = HARD; exp_b = HARD; exp_c = HARD;
    @(negedge clk);
    check("R3", "peer after reset", qa, HARD);

    // write and hold sweep
    for (int v = 0; v < 256; v++) begin
      drive(1'b1, 8'(v), 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      check("R2", "peer", qa, 8'(v)); check("R2", "hw", qb, 8'(v)); check("R2", "param", qc, 8'(v));
      drive(1'b0, ~8'(v), 1'b0, 1'b0, 1'b0, 8'(v + 5), 8'(v + 9));
      check("R3", "peer", qa, 8'(v)); check("R3", "hw", qb, 8'(v)); check("R3", "param", qc, 8'(v));
    end

    // soft reset sweep, with a competing write on odd values
    for (int v = 0; v < 256; v++) begin
      logic [7:0] pv, hv;
      pv = 8'(v); hv = 8'(v + 37);
      drive(pv[0], ~pv, 1'b1, 1'b1, 1'b1, pv, hv);
      check(pv[0] ? "R7" : "R4", "peer source", qa, exp_a);
      check(pv[0] ? "R7" : "R5", "hw source", qb, exp_b);
      check(pv[0] ? "R7" : "R6", "param source", qc, exp_c);
      check("R4", "peer model", exp_a, pv);
      check("R5", "hw model", exp_b, hv);
      check("R6", "param model", exp_c, SOFT);
      drive(1'b1, pv ^ 8'h5C, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      check("R11", "peer", qa, pv ^ 8'h5C); check("R11", "hw", qb, pv ^ 8'h5C);
      check("R11", "param", qc, pv ^ 8'h5C);
    end

    // async soft reset held across edges while the source moves
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 8'h40);
    for (int k = 1; k < 5; k++) begin
      drive(1'b1, 8'hEE, 1'b0, 1'b1, 1'b0, 8'h00, 8'(8'h40 + k));
      check("R9", "reload while held", qb, 8'(8'h40 + k));
    end
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h99);
    check("R9", "keeps last load", qb, 8'h44);

    // polarity: opposite levels do nothing, active level acts
    drive(1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 8'hA1, 8'hB2);
    check("R10", "high-active idle at 0", qa, 8'h3C);
    check("R10", "low-active idle at 1", qb, 8'h3C);
    check("R10", "low-active idle at 1", qc, 8'h3C);
    drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hA1, 8'hB2);
    check("R10", "high-active acts at 1", qa, 8'hA1);
    check("R10", "low-active untouched", qb, 8'h3C);
    check("R10", "low-active untouched", qc, 8'h3C);

    // hard reset acts without a clock
    hard_rst_n = 1'b0;
    #2;
    check("R1", "async hard peer", qa, HARD); check("R1", "async hard hw", qb, HARD);
    check("R1", "async hard param", qc, HARD);
    @(negedge clk);
    hard_rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule